// File: doc/BRIEF.md
# UART Line Status Flag Tracker

This block holds two bits of a UART channel's line status word. The first is the transmitter-idle bit, which tells the host that the holding register and the shift register have both drained. The second is the sticky data-error bit. It records that at least one received character reached the host with a parity error, a framing error or a break condition.

The receive path pulses a transfer strobe each time a character moves into the receive holding register, and it presents that character's three error flags in the same cycle. The host's read of the line status word arrives as a one-cycle strobe. The error bit seen on that cycle is the value held before the read. The bit is cleared on the following edge.

Two mode selects change the error bit:
- Legacy compatibility mode pins the error bit at zero.
- 9-bit framing mode disables parity checking, so the parity flag is disregarded.

Top module: `lsr_flag_tracker`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) leaves `xmit_idle_o` at 1 and `data_err_o` at 0.
- R2: One edge after the inputs are sampled, `xmit_idle_o` equals `thr_empty_i` AND `tsr_empty_i`, so it is 0 whenever either register holds data.
- R3: Outside legacy mode, a cycle with `rx_xfer_i` high and `rx_frame_err_i` or `rx_break_i` high sets `data_err_o` to 1 from the next edge.
- R4: With both mode selects low, a transfer carrying only `rx_parity_err_i` sets `data_err_o` to 1 from the next edge.
- R5: With `nine_bit_mode_i` high, a transfer carrying only the parity flag leaves `data_err_o` unchanged. A framing or break flag still sets the bit.
- R6: A one-cycle `lsr_rd_i` pulse with no faulty transfer in that cycle leaves `data_err_o` at its held value during the pulse and clears it to 0 from the next edge.
- R7: When a faulty transfer and `lsr_rd_i` fall in the same cycle, `data_err_o` is 1 after that edge.
- R8: While `legacy_mode_i` is high, `data_err_o` is 0 in the same cycle, whatever the other inputs do. The held error state is discarded, so after leaving legacy mode the bit stays 0 until a new faulty transfer.
- R9: Error flags presented without `rx_xfer_i`, and transfers with all three flags low, leave `data_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |
| rx_xfer_i | input | 1 | A received character moves into the receive holding register this cycle |
| rx_parity_err_i | input | 1 | Parity error flag of the transferred character |
| rx_frame_err_i | input | 1 | Framing error flag of the transferred character |
| rx_break_i | input | 1 | Break flag of the transferred character |
| lsr_rd_i | input | 1 | One-cycle strobe for a host read of the line status word |
| legacy_mode_i | input | 1 | Legacy compatibility mode; forces the error bit low |
| nine_bit_mode_i | input | 1 | 9-bit framing mode; parity flag is ignored |
| xmit_idle_o | output | 1 | Transmitter-idle status bit |
| data_err_o | output | 1 | Sticky receiver data-error status bit |

## Verification
The set path and the clear path of the error bit can meet in one cycle: a faulty character is handed over while the host reads the status word. The bench first sets the bit. It then drives the read strobe and a break-flagged transfer together in a single cycle. The bit must still read 1 after that edge, and a later read with no transfer must clear it. The same collision is also driven with a parity-only transfer in 9-bit mode, where the read must win and leave the bit at 0.

// File: rtl/lsr_flag_pkg.sv
package lsr_flag_pkg;

    // Error flags that travel with one received character
    typedef struct packed {
        logic parity;
        logic framing;
        logic brk;
    } rx_flags_t;

    // Next-state action for the sticky error bit
    typedef enum logic [1:0] {
        ERR_KEEP  = 2'd0,
        ERR_SET   = 2'd1,
        ERR_CLEAR = 2'd2
    } err_act_t;

    localparam logic IDLE_AT_RESET = 1'b1;
    localparam logic ERR_AT_RESET  = 1'b0;

    // A character counts as faulty when framing or break is flagged.
    // Parity counts only when parity checking is active (not 9-bit mode).
    function automatic logic char_is_faulty(input rx_flags_t f, input logic nine_bit);
        return f.framing | f.brk | (f.parity & ~nine_bit);
    endfunction

endpackage

// File: rtl/lsr_xmit_idle.sv
module lsr_xmit_idle
    import lsr_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic tsr_empty,
    output logic idle
);
    logic idle_q;

    always_ff @(posedge clk) begin
        if (rst) idle_q <= IDLE_AT_RESET;
        else     idle_q <= thr_empty & tsr_empty;
    end

    assign idle = idle_q;
endmodule

// File: rtl/lsr_fault_qual.sv
module lsr_fault_qual
    import lsr_flag_pkg::*;
(
    input  logic      xfer,
    input  rx_flags_t flags,
    input  logic      rd,
    input  logic      legacy,
    input  logic      nine_bit,
    output err_act_t  act
);
    logic faulty;

    assign faulty = xfer & char_is_faulty(flags, nine_bit);

    // A set takes priority over a read clear so that a new error is kept.
    // Legacy mode discards any held state.
    always_comb begin
        if (legacy)      act = ERR_CLEAR;
        else if (faulty) act = ERR_SET;
        else if (rd)     act = ERR_CLEAR;
        else             act = ERR_KEEP;
    end
endmodule

// File: rtl/lsr_err_hold.sv
module lsr_err_hold
    import lsr_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_act_t act,
    input  logic     legacy,
    output logic     err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= ERR_AT_RESET;
        end else begin
            unique case (act)
                ERR_SET:   err_q <= 1'b1;
                ERR_CLEAR: err_q <= 1'b0;
                default:   err_q <= err_q;
            endcase
        end
    end

    // The bit is masked in the same cycle that legacy mode is selected
    assign err = err_q & ~legacy;
endmodule

// File: rtl/lsr_flag_tracker.sv
module lsr_flag_tracker
    import lsr_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic thr_empty_i,
    input  logic tsr_empty_i,
    input  logic rx_xfer_i,
    input  logic rx_parity_err_i,
    input  logic rx_frame_err_i,
    input  logic rx_break_i,
    input  logic lsr_rd_i,
    input  logic legacy_mode_i,
    input  logic nine_bit_mode_i,
    output logic xmit_idle_o,
    output logic data_err_o
);
    rx_flags_t rx_flags;
    err_act_t  err_act;

    assign rx_flags = '{parity: rx_parity_err_i, framing: rx_frame_err_i, brk: rx_break_i};

    lsr_xmit_idle u_idle (
        .clk       (clk),
        .rst       (rst),
        .thr_empty (thr_empty_i),
        .tsr_empty (tsr_empty_i),
        .idle      (xmit_idle_o)
    );

    lsr_fault_qual u_qual (
        .xfer     (rx_xfer_i),
        .flags    (rx_flags),
        .rd       (lsr_rd_i),
        .legacy   (legacy_mode_i),
        .nine_bit (nine_bit_mode_i),
        .act      (err_act)
    );

    lsr_err_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .act    (err_act),
        .legacy (legacy_mode_i),
        .err    (data_err_o)
    );
endmodule

// File: rtl/lsr_flag_checker.sv
module lsr_flag_checker (
    input logic clk,
    input logic rst,
    input logic thr_empty_i,
    input logic tsr_empty_i,
    input logic rx_xfer_i,
    input logic rx_parity_err_i,
    input logic rx_frame_err_i,
    input logic rx_break_i,
    input logic lsr_rd_i,
    input logic legacy_mode_i,
    input logic nine_bit_mode_i,
    input logic xmit_idle_o,
    input logic data_err_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (xmit_idle_o && !data_err_o));

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        (thr_empty_i && tsr_empty_i) |=> xmit_idle_o);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !(thr_empty_i && tsr_empty_i) |=> !xmit_idle_o);

    assert_frame_break_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_xfer_i && (rx_frame_err_i || rx_break_i) && !legacy_mode_i)
        |=> (data_err_o || legacy_mode_i));

    assert_parity_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_xfer_i && rx_parity_err_i && !nine_bit_mode_i && !legacy_mode_i)
        |=> (data_err_o || legacy_mode_i));

    assert_ninebit_parity_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_xfer_i && rx_parity_err_i && !rx_frame_err_i && !rx_break_i
         && nine_bit_mode_i && !lsr_rd_i && !data_err_o)
        |=> !data_err_o);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd_i && !(rx_xfer_i && (rx_frame_err_i || rx_break_i
                       || (rx_parity_err_i && !nine_bit_mode_i))))
        |=> !data_err_o);

    assert_collision_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd_i && rx_xfer_i && (rx_frame_err_i || rx_break_i) && !legacy_mode_i)
        |=> (data_err_o || legacy_mode_i));

    assert_legacy_masks_R8: assert property (@(posedge clk) disable iff (rst)
        legacy_mode_i |-> !data_err_o);

    assert_no_xfer_keeps_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_xfer_i && !data_err_o) |=> !data_err_o);

    assert_clean_keeps_high_R9: assert property (@(posedge clk) disable iff (rst)
        (data_err_o && !lsr_rd_i && !legacy_mode_i)
        |=> (data_err_o || legacy_mode_i));
endmodule

bind lsr_flag_tracker lsr_flag_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .thr_empty_i     (thr_empty_i),
    .tsr_empty_i     (tsr_empty_i),
    .rx_xfer_i       (rx_xfer_i),
    .rx_parity_err_i (rx_parity_err_i),
    .rx_frame_err_i  (rx_frame_err_i),
    .rx_break_i      (rx_break_i),
    .lsr_rd_i        (lsr_rd_i),
    .legacy_mode_i   (legacy_mode_i),
    .nine_bit_mode_i (nine_bit_mode_i),
    .xmit_idle_o     (xmit_idle_o),
    .data_err_o      (data_err_o)
);

// File: tb/sim_lsr_flag_tracker.sv
`timescale 1ns/1ps
module sim_lsr_flag_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic thr_empty = 1'b1, tsr_empty = 1'b1;
    logic xfer = 1'b0, par = 1'b0, frm = 1'b0, brk = 1'b0;
    logic rd = 1'b0, legacy = 1'b0, nine = 1'b0;
    logic idle_o, err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lsr_flag_tracker u0 (
        .clk             (clk),
        .rst             (rst),
        .thr_empty_i     (thr_empty),
        .tsr_empty_i     (tsr_empty),
        .rx_xfer_i       (xfer),
        .rx_parity_err_i (par),
        .rx_frame_err_i  (frm),
        .rx_break_i      (brk),
        .lsr_rd_i        (rd),
        .legacy_mode_i   (legacy),
        .nine_bit_mode_i (nine),
        .xmit_idle_o     (idle_o),
        .data_err_o      (err_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drop_rx();
        xfer = 0; par = 0; frm = 0; brk = 0; rd = 0;
    endtask

    task automatic deliver(input logic p, input logic f, input logic b);
        xfer = 1; par = p; frm = f; brk = b;
        step();
        drop_rx();
    endtask

    task automatic read_status();
        rd = 1;
        step();
        rd = 0;
    endtask

    task automatic t_reset();
        check(idle_o, 1'b1, "R1 idle after reset");
        check(err_o, 1'b0, "R1 error after reset");
    endtask

    task automatic t_idle();
        for (int k = 0; k < 4; k++) begin
            thr_empty = k[0];
            tsr_empty = k[1];
            step();
            check(idle_o, k[0] & k[1], $sformatf("R2 idle thr=%0d tsr=%0d", k[0], k[1]));
        end
        thr_empty = 1; tsr_empty = 1;
        step();
    endtask

    task automatic t_frame_and_read();
        deliver(0, 1, 0);
        check(err_o, 1'b1, "R3 framing error sets");
        rd = 1;
        #1;
        check(err_o, 1'b1, "R6 value held during read");
        step();
        rd = 0;
        check(err_o, 1'b0, "R6 read clears");
        deliver(0, 0, 1);
        check(err_o, 1'b1, "R3 break sets");
        read_status();
        check(err_o, 1'b0, "R6 clear after break");
    endtask

    task automatic t_parity_normal();
        deliver(1, 0, 0);
        check(err_o, 1'b1, "R4 parity sets in normal mode");
        read_status();
    endtask

    task automatic t_ninebit();
        nine = 1;
        deliver(1, 0, 0);
        check(err_o, 1'b0, "R5 parity ignored in 9-bit mode");
        deliver(1, 1, 0);
        check(err_o, 1'b1, "R5 framing still sets in 9-bit mode");
        // read collides with a parity-only transfer: the read wins
        xfer = 1; par = 1; rd = 1;
        step();
        drop_rx();
        check(err_o, 1'b0, "R5 parity collision in 9-bit mode clears");
        nine = 0;
    endtask

    task automatic t_collide();
        deliver(0, 1, 0);
        xfer = 1; brk = 1; rd = 1;
        step();
        drop_rx();
        check(err_o, 1'b1, "R7 error kept on simultaneous read");
        read_status();
        check(err_o, 1'b0, "R7 later read clears");
    endtask

    task automatic t_legacy();
        deliver(0, 0, 1);
        legacy = 1;
        #1;
        check(err_o, 1'b0, "R8 masked as soon as legacy selected");
        deliver(1, 1, 1);
        check(err_o, 1'b0, "R8 faulty transfer ignored in legacy");
        legacy = 0;
        #1;
        check(err_o, 1'b0, "R8 no stale error after leaving legacy");
        step();
        check(err_o, 1'b0, "R8 stays clear after leaving legacy");
    endtask

    task automatic t_ignored();
        par = 1; frm = 1; brk = 1;
        step();
        drop_rx();
        check(err_o, 1'b0, "R9 flags without strobe ignored");
        deliver(0, 0, 0);
        check(err_o, 1'b0, "R9 clean transfer leaves bit low");
        deliver(0, 1, 0);
        deliver(0, 0, 0);
        check(err_o, 1'b1, "R9 clean transfer leaves bit high");
        read_status();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        t_reset();
        t_idle();
        t_frame_and_read();
        t_parity_normal();
        t_ninebit();
        t_collide();
        t_legacy();
        t_ignored();
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end
endmodule